// File: doc/BRIEF.md
# Three-Row Pixel Window Buffer

This block keeps three image lines of `COLS` eight-bit pixels. A host writes them one byte at a time over a strobed byte bus. Every byte goes into the bottom line, from the left-most column rightwards. A command byte presented with a separate command strobe moves every line up by one. The top line is lost and the bottom line is emptied for the next image line. A synchronous clear empties the whole buffer before a new image is processed.

The block exposes `COLS-2` overlapping 3x3 windows at the same time, one per output column, for a bank of edge operators. The windows are a static view of the stored state: they change only when a byte, a command or a clear is applied. For that reason the window side carries a level `win_valid` flag and no valid/ready handshake, and there is no back-pressure on either side. The host side keeps the active-low strobe handshake that its port drives.

The two strobes are asynchronous to `clk`. Each one is passed through a two-stage synchroniser and acts once, on its falling edge. The action reaches the storage on the third rising edge of `clk` after the strobe goes low. The bus and the qualifier inputs must be held stable while a strobe is low and for three clock cycles after it.

Top module: `pix_row_buffer`

## Requirements
- R1: After `rst_n` low, or on the edge after `clr` is high for one cycle, every stored pixel reads zero, the write column returns to 0 and `win_valid` is low.
- R2: A falling edge on `dat_stb_n` while `hst_rdy_n` and `hst_rw` are both low writes `hst_bus` into the bottom row at the current write column, then advances the column by one; consecutive bytes fill columns 0, 1, 2 … in order.
- R3: A data strobe that arrives while `hst_rdy_n` is high, or while `hst_rw` is high, changes no stored pixel and does not move the write column.
- R4: Once `COLS` bytes have been written into the bottom row, further data strobes are ignored until the next shift or clear.
- R5: A falling edge on `mod_stb_n` with `hst_bus` equal to 8'h66 copies the middle row into the top row and the bottom row into the middle row, zeroes the bottom row and returns the write column to 0.
- R6: A command strobe carrying any other bus value changes nothing.
- R7: Each strobe acts exactly once, however many clock cycles it stays low.
- R8: Window k (0 ≤ k < COLS-2) holds rows 0 (top) to 2 (bottom) at columns k, k+1 and k+2; the pixel of row r and window column c (c = 0..2) sits at `win_o[((k*9)+r*3+c)*8 +: 8]`.
- R9: `win_valid` rises when the third bottom row since the last clear or reset is completely written (its byte in column `COLS-1`), and stays high through later shifts and writes until the next clear or reset.
- R10: When both strobes fall in the same cycle with the shift code on the bus, the shift takes place and the byte is dropped, so the next accepted byte lands in column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of the whole buffer |
| hst_bus | input | 8 | Host byte bus: a pixel or a command code |
| hst_rw | input | 1 | Transfer direction; low means host writes |
| hst_rdy_n | input | 1 | Host ready, active low; qualifies byte writes |
| dat_stb_n | input | 1 | Data strobe, active low, asynchronous |
| mod_stb_n | input | 1 | Command strobe, active low, asynchronous |
| win_o | output | (COLS-2)*72 | All 3x3 windows, packed as in R8 |
| win_valid | output | 1 | Three full rows loaded since the last clear |

## Verification
The bench builds the block with its default of 34 columns and 8-bit pixels. At that size it can reach the saturation of the write column after the 34th byte and see all 32 windows, so every stored pixel shows up in some window. Because of this, an ignored byte or command can be seen directly at `win_o`. With the same parameters the bench also drives strobes of one and of eight clock cycles, and strobes that fall together.

// File: rtl/pix_row_buffer_pkg.sv
package pix_row_buffer_pkg;
  // One action per clock on the storage; order here is the priority order.
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_WRITE = 2'd1,
    ACT_SHIFT = 2'd2,
    ACT_CLEAR = 2'd3
  } act_e;

  localparam int ROWS = 3;   // window height
  localparam int WCOLS = 3;  // window width
endpackage

// File: rtl/strobe_fall.sv
// Synchronises an active-low asynchronous strobe and flags its falling edge
module strobe_fall #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic fall
);
  logic [SYNC:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[SYNC-1:0], strobe_n};
  end

  // Oldest stage still high, next stage low: one-cycle pulse per strobe.
  assign fall = sh[SYNC] & ~sh[SYNC-1];
endmodule

// File: rtl/buf_ctrl.sv
// Decodes strobes into one action per cycle and tracks the write column
module buf_ctrl
  import pix_row_buffer_pkg::*;
#(
  parameter int COLS = 34,
  parameter int PIX_W = 8,
  parameter logic [7:0] SHIFT_CODE = 8'h66,
  localparam int PTR_W = $clog2(COLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             data_fall,
  input  logic             mode_fall,
  input  logic [7:0]       hst_bus,
  input  logic             hst_rw,
  input  logic             hst_rdy_n,
  output act_e             act,
  output logic [PTR_W-1:0] wr_col,
  output logic [PIX_W-1:0] wr_byte,
  output logic             win_valid
);
  localparam logic [PTR_W-1:0] FULL = PTR_W'(COLS);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(COLS - 1);

  logic [1:0] rows_done;
  logic       can_write;

  assign can_write = data_fall && !hst_rdy_n && !hst_rw && (wr_col < FULL);

  always_comb begin
    if (clr)                                  act = ACT_CLEAR;
    else if (mode_fall && hst_bus == SHIFT_CODE) act = ACT_SHIFT;
    else if (can_write)                       act = ACT_WRITE;
    else                                      act = ACT_NONE;
  end

  assign wr_byte = hst_bus[PIX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_col    <= '0;
      rows_done <= '0;
    end else begin
      unique case (act)
        ACT_CLEAR: begin
          wr_col    <= '0;
          rows_done <= '0;
        end
        ACT_SHIFT: wr_col <= '0;
        ACT_WRITE: begin
          wr_col <= wr_col + PTR_W'(1);
          if (wr_col == LAST && rows_done != 2'd3)
            rows_done <= rows_done + 2'd1;
        end
        default: ;
      endcase
    end
  end

  assign win_valid = (rows_done == 2'd3);
endmodule

// File: rtl/row_store.sv
// Three rows of pixels; each column is a three-deep upward shift stage
module row_store
  import pix_row_buffer_pkg::*;
#(
  parameter int COLS = 34,
  parameter int PIX_W = 8,
  localparam int PTR_W = $clog2(COLS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  act_e                        act,
  input  logic [PTR_W-1:0]            wr_col,
  input  logic [PIX_W-1:0]            wr_byte,
  output logic [ROWS*COLS*PIX_W-1:0]  rows_flat
);
  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [PIX_W-1:0] top, mid, bot;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        top <= '0;
        mid <= '0;
        bot <= '0;
      end else begin
        unique case (act)
          ACT_CLEAR: begin
            top <= '0;
            mid <= '0;
            bot <= '0;
          end
          ACT_SHIFT: begin
            top <= mid;
            mid <= bot;
            bot <= '0;
          end
          ACT_WRITE: if (wr_col == PTR_W'(c)) bot <= wr_byte;
          default: ;
        endcase
      end
    end

    assign rows_flat[(0*COLS + c)*PIX_W +: PIX_W] = top;
    assign rows_flat[(1*COLS + c)*PIX_W +: PIX_W] = mid;
    assign rows_flat[(2*COLS + c)*PIX_W +: PIX_W] = bot;
  end
endmodule

// File: rtl/win_map.sv
// Wires overlapping 3x3 windows out of the stored rows
module win_map
  import pix_row_buffer_pkg::*;
#(
  parameter int COLS = 34,
  parameter int PIX_W = 8,
  localparam int NWIN = COLS - 2,
  localparam int WPIX = ROWS * WCOLS
) (
  input  logic [ROWS*COLS*PIX_W-1:0]  rows_flat,
  output logic [NWIN*WPIX*PIX_W-1:0]  win_flat
);
  for (genvar k = 0; k < NWIN; k++) begin : g_win
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < WCOLS; c++) begin : g_col
        assign win_flat[(k*WPIX + r*WCOLS + c)*PIX_W +: PIX_W] =
          rows_flat[(r*COLS + k + c)*PIX_W +: PIX_W];
      end
    end
  end
endmodule

// File: rtl/pix_row_buffer.sv
module pix_row_buffer
  import pix_row_buffer_pkg::*;
#(
  parameter int COLS = 34,
  parameter int PIX_W = 8,
  parameter logic [7:0] SHIFT_CODE = 8'h66,
  localparam int NWIN = COLS - 2,
  localparam int PTR_W = $clog2(COLS + 1),
  localparam int WIN_BITS = NWIN * ROWS * WCOLS * PIX_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic [7:0]          hst_bus,
  input  logic                hst_rw,
  input  logic                hst_rdy_n,
  input  logic                dat_stb_n,
  input  logic                mod_stb_n,
  output logic [WIN_BITS-1:0] win_o,
  output logic                win_valid
);
  logic                       data_fall, mode_fall;
  act_e                       act;
  logic [PTR_W-1:0]           wr_col;
  logic [PIX_W-1:0]           wr_byte;
  logic [ROWS*COLS*PIX_W-1:0] rows_flat;

  strobe_fall #(.SYNC(2)) u_dat_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(dat_stb_n), .fall(data_fall)
  );

  strobe_fall #(.SYNC(2)) u_mod_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(mod_stb_n), .fall(mode_fall)
  );

  buf_ctrl #(.COLS(COLS), .PIX_W(PIX_W), .SHIFT_CODE(SHIFT_CODE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .data_fall(data_fall), .mode_fall(mode_fall),
    .hst_bus(hst_bus), .hst_rw(hst_rw), .hst_rdy_n(hst_rdy_n),
    .act(act), .wr_col(wr_col), .wr_byte(wr_byte), .win_valid(win_valid)
  );

  row_store #(.COLS(COLS), .PIX_W(PIX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .act(act),
    .wr_col(wr_col), .wr_byte(wr_byte), .rows_flat(rows_flat)
  );

  win_map #(.COLS(COLS), .PIX_W(PIX_W)) u_map (
    .rows_flat(rows_flat), .win_flat(win_o)
  );
endmodule

// File: rtl/pix_row_buffer_chk.sv
module pix_row_buffer_chk
  import pix_row_buffer_pkg::*;
#(
  parameter int COLS = 34,
  parameter int PIX_W = 8,
  localparam int PTR_W = $clog2(COLS + 1),
  localparam int RW = COLS * PIX_W
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       clr,
  input act_e                       act,
  input logic [PTR_W-1:0]           wptr,
  input logic [ROWS*COLS*PIX_W-1:0] rows,
  input logic                       win_valid
);
  localparam logic [PTR_W-1:0] FULL = PTR_W'(COLS);

  logic [RW-1:0] top_r, mid_r, bot_r;
  assign top_r = rows[0*RW +: RW];
  assign mid_r = rows[1*RW +: RW];
  assign bot_r = rows[2*RW +: RW];

  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (wptr == '0 && !win_valid && rows == '0));

  p_write_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_WRITE |=> wptr == $past(wptr) + PTR_W'(1));

  p_ptr_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wptr <= FULL);

  p_full_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wptr == FULL && act != ACT_SHIFT && act != ACT_CLEAR)
      |=> ($stable(bot_r) && wptr == FULL));

  p_shift_move_r5: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_SHIFT |=> (top_r == $past(mid_r) && mid_r == $past(bot_r)
                          && bot_r == '0 && wptr == '0));

  p_valid_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && !clr) |=> win_valid);
endmodule

bind pix_row_buffer pix_row_buffer_chk #(.COLS(COLS), .PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .act(act),
  .wptr(wr_col), .rows(rows_flat), .win_valid(win_valid)
);

// File: tb/sim_pix_row_buffer.sv
`timescale 1ns/1ps
module sim_pix_row_buffer;
  localparam int COLS = 34;
  localparam int NWIN = COLS - 2;
  localparam int WW = NWIN * 9 * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic [7:0] hst_bus = 8'h00;
  logic hst_rw = 1'b0;
  logic hst_rdy_n = 1'b0;
  logic dat_stb_n = 1'b1;
  logic mod_stb_n = 1'b1;
  logic [WW-1:0] win_o;
  logic win_valid;

  always #2 clk = ~clk;  // 250 MHz

  pix_row_buffer u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .hst_bus(hst_bus), .hst_rw(hst_rw),
    .hst_rdy_n(hst_rdy_n), .dat_stb_n(dat_stb_n), .mod_stb_n(mod_stb_n),
    .win_o(win_o), .win_valid(win_valid)
  );

  // Reference model
  logic [7:0] m [0:2][0:COLS-1];
  int mptr = 0;
  int mfills = 0;

  // Scoreboard
  logic [WW-1:0] q_win [$];
  logic          q_vld [$];
  string         q_tag [$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  function automatic logic [WW-1:0] model_win();
    logic [WW-1:0] v = '0;
    for (int k = 0; k < NWIN; k++)
      for (int r = 0; r < 3; r++)
        for (int c = 0; c < 3; c++)
          v[(k*9 + r*3 + c)*8 +: 8] = m[r][k+c];
    return v;
  endfunction

  task automatic model_clear();
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < COLS; c++) m[r][c] = 8'h00;
    mptr = 0;
    mfills = 0;
  endtask

  task automatic model_shift();
    for (int c = 0; c < COLS; c++) begin
      m[0][c] = m[1][c];
      m[1][c] = m[2][c];
      m[2][c] = 8'h00;
    end
    mptr = 0;
  endtask

  task automatic expect_now(input string tag);
    @(posedge clk);
    q_win.push_back(model_win());
    q_vld.push_back(mfills == 3);
    q_tag.push_back(tag);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic rdy_n,
                           input logic rw, input int low);
    @(negedge clk);
    hst_bus = b; hst_rdy_n = rdy_n; hst_rw = rw;
    dat_stb_n = 1'b0;
    repeat (low) @(negedge clk);
    dat_stb_n = 1'b1;
    repeat (5) @(negedge clk);
    hst_rdy_n = 1'b0; hst_rw = 1'b0;
    if (!rdy_n && !rw && mptr < COLS) begin
      m[2][mptr] = b;
      if (mptr == COLS - 1 && mfills < 3) mfills++;
      mptr++;
    end
  endtask

  task automatic send_mode(input logic [7:0] code, input int low);
    @(negedge clk);
    hst_bus = code;
    mod_stb_n = 1'b0;
    repeat (low) @(negedge clk);
    mod_stb_n = 1'b1;
    repeat (5) @(negedge clk);
    if (code == 8'h66) model_shift();
  endtask

  task automatic send_both();
    @(negedge clk);
    hst_bus = 8'h66;
    dat_stb_n = 1'b0; mod_stb_n = 1'b0;
    @(negedge clk);
    dat_stb_n = 1'b1; mod_stb_n = 1'b1;
    repeat (5) @(negedge clk);
    model_shift();
  endtask

  task automatic fill(input int seed, input int from, input int upto);
    for (int i = from; i < upto; i++)
      send_byte(8'((i * 37 + seed * 11 + 5) & 8'hFF), 1'b0, 1'b0, 1);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (q_win.size() > 0) begin
      logic [WW-1:0] ew;
      logic ev;
      string t;
      ew = q_win.pop_front();
      ev = q_vld.pop_front();
      t = q_tag.pop_front();
      n_cmp++;
      if (win_o !== ew || win_valid !== ev) begin
        n_bad++;
        $display("FAIL %s: win_o=%h valid=%b expected win_o=%h valid=%b",
                 t, win_o, win_valid, ew, ev);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_now("R1 reset state");

    fill(1, 0, 5);
    expect_now("R2 first five bytes in columns 0..4");
    fill(1, 5, COLS);
    expect_now("R8 full bottom row spread over windows");

    send_byte(8'hEE, 1'b0, 1'b0, 1);
    expect_now("R4 byte after full row ignored");

    send_mode(8'h55, 1);
    expect_now("R6 non-shift command ignored");

    send_mode(8'h66, 1);
    expect_now("R5 shift moves rows up and empties bottom");

    send_byte(8'hA5, 1'b1, 1'b0, 1);
    expect_now("R3 byte with ready high ignored");
    send_byte(8'h5A, 1'b0, 1'b1, 1);
    expect_now("R3 byte with rw high ignored");

    send_byte(8'h3C, 1'b0, 1'b0, 8);
    send_byte(8'hC3, 1'b0, 1'b0, 1);
    expect_now("R7 long data strobe writes once");

    fill(2, 2, COLS);
    expect_now("R9 two rows loaded, still not valid");
    send_mode(8'h66, 1);
    fill(3, 0, COLS - 1);
    expect_now("R9 third row one byte short");
    fill(3, COLS - 1, COLS);
    expect_now("R9 valid after third full row, R8 windows");

    send_both();
    expect_now("R10 simultaneous strobes shift and drop byte");
    send_byte(8'h77, 1'b0, 1'b0, 1);
    expect_now("R10 next byte lands in column 0, R9 valid held");

    send_mode(8'h66, 8);
    expect_now("R7 long command strobe shifts once");

    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    model_clear();
    expect_now("R1 clear empties buffer");

    repeat (4) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule